// File: doc/BRIEF.md
# Background Tile Pixel Fetcher

This block produces the background pixel stream of a tile-based video processor. The visible area is 32 by 30 tiles of 8x8 pixels, which gives 256x240 pixels. On each scanline the block walks the tile columns from left to right. For each column it reads a tile index and a 2-bit palette group from nametable memory. It then reads the low and high bit-plane bytes for the current pixel row of that tile from pattern memory. The two planes are merged into 2-bit pixel values. Each pixel value and its palette group select an entry of a 32-byte palette RAM, and that entry holds a 6-bit master colour index.

A controller pulses `line_start_i` once per visible line and presents the line number and the table selections at the same time. All three memories are external and have a registered read port with one clock of latency. Tile fetches run one tile ahead of the pixels being shown. The block then emits 256 colour indices, one per clock, each marked with a valid flag.

Top module: `bg_tile_fetch`

## Requirements
- R1: While reset is held and after it is released, `color_valid_o` and `color_o` are 0 until a line is started.
- R2: Tile column c (0..31) of line y is read from the nametable at address {bank, y[7:3], c[4:0]}. This address is on `nt_addr_o` during the cycle 8c clocks after the edge that samples `line_start_i`.
- R3: The nametable bank bit is `nt_sel_i[1]` when `mirror_i` is 1 (horizontal mirroring) and `nt_sel_i[0]` when `mirror_i` is 0 (vertical mirroring).
- R4: The pattern row address is {pt_sel, tile[7:0], plane, y[2:0]}. The low plane (plane=0) is on `pat_addr_o` 2 clocks after the tile's nametable read, and the high plane, 8 bytes above it, is there 4 clocks after.
- R5: The pixel value is {high_plane_bit, low_plane_bit}. Bit 7 of each plane is the leftmost pixel of the tile.
- R6: The palette address is {1'b0, group[1:0], pixel[1:0]}. A pixel value of 0 always reads address 0 (the shared backdrop), whatever the group.
- R7: Pixel p (0..255) of a line is on `color_o` with `color_valid_o`=1 during the cycle 11+p clocks after the line-start edge. It equals the palette data read for that pixel. Valid is high for exactly 256 consecutive cycles.
- R8: `line_y_i`, `nt_sel_i`, `pt_sel_i` and `mirror_i` are sampled only at line start. Changing them later in the line has no effect on that line's output.
- R9: Without a line start, `color_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse that begins a line |
| line_y_i | input | 8 | Visible line number, 0..239 |
| nt_sel_i | input | 2 | Logical nametable select |
| pt_sel_i | input | 1 | Pattern table half select |
| mirror_i | input | 1 | 1 = horizontal mirroring, 0 = vertical |
| nt_addr_o | output | 11 | Nametable read address |
| nt_tile_i | input | 8 | Tile index read data |
| nt_attr_i | input | 2 | Palette group read with the tile |
| pat_addr_o | output | 13 | Pattern table read address |
| pat_data_i | input | 8 | Pattern plane byte |
| pal_addr_o | output | 5 | Palette RAM read address |
| pal_data_i | input | 6 | Palette RAM read data |
| color_o | output | 6 | Master colour index of the pixel |
| color_valid_o | output | 1 | Pixel valid |

## Verification
The bench goes after the first and last pixel of a line, line 0 and line 239, both mirroring settings, and mid-line changes to the sampled inputs. If the pipeline were off by one clock, every colour compare would shift by one pixel. If the plane order or bit order were swapped, pixels inside each tile would come out mirrored or recoloured. If the backdrop were not forced, pixels with value 0 would show the colour of their own group instead of the shared entry. If an input were sampled live rather than at line start, the line would switch to other tiles partway across.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  localparam int COLS      = 32;
  localparam int TILE_PX   = 8;
  localparam int FX_W      = 9;
  localparam int Y_W       = 8;
  localparam int FY_W      = 3;
  localparam int COL_W     = 5;
  localparam int TILE_W    = 8;
  localparam int GRP_W     = 2;
  localparam int PIX_W     = 2;
  localparam int CIDX_W    = 6;
  localparam int NT_AW     = 1 + (Y_W - FY_W) + COL_W;
  localparam int PAT_AW    = 1 + TILE_W + 1 + FY_W;
  localparam int PAL_AW    = 1 + GRP_W + PIX_W;
  localparam int LINE_PX   = COLS * TILE_PX;
  localparam int LINE_LAST = LINE_PX + TILE_PX - 1;
  typedef logic [FX_W-1:0] fx_t;
endpackage

// File: rtl/bgf_seq.sv
module bgf_seq
  import bgf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [Y_W-1:0]    line_y_i,
  input  logic [1:0]        nt_sel_i,
  input  logic              pt_sel_i,
  input  logic              mirror_i,
  input  logic [TILE_W-1:0] nt_tile_i,
  input  logic [GRP_W-1:0]  nt_attr_i,
  output logic [NT_AW-1:0]  nt_addr_o,
  output logic [PAT_AW-1:0] pat_addr_o,
  output logic              active_o,
  output logic              lo_stb_o,
  output logic              hi_stb_o,
  output logic              load_o,
  output logic              vis_o,
  output logic [GRP_W-1:0]  attr_o
);
  logic              active_q;
  fx_t               fx_q;
  logic [Y_W-1:0]    y_q;
  logic              bank_q, pt_q;
  logic [TILE_W-1:0] tile_q;
  logic [GRP_W-1:0]  attr_q;
  logic [2:0]        phase;
  logic              fetch;

  assign phase = fx_q[2:0];
  assign fetch = active_q && (fx_q < fx_t'(LINE_PX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      fx_q     <= '0;
      y_q      <= '0;
      bank_q   <= 1'b0;
      pt_q     <= 1'b0;
    end else if (line_start_i) begin
      active_q <= 1'b1;
      fx_q     <= '0;
      y_q      <= line_y_i;
      bank_q   <= mirror_i ? nt_sel_i[1] : nt_sel_i[0];
      pt_q     <= pt_sel_i;
    end else if (active_q) begin
      fx_q <= fx_q + fx_t'(1);
      if (fx_q == fx_t'(LINE_LAST)) active_q <= 1'b0;
    end
  end

  // tile data returns one clock after the phase-0 address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tile_q <= '0;
      attr_q <= '0;
    end else if (fetch && phase == 3'd1) begin
      tile_q <= nt_tile_i;
      attr_q <= nt_attr_i;
    end
  end

  assign nt_addr_o  = {bank_q, y_q[Y_W-1:FY_W], fx_q[COL_W+2:3]};
  assign pat_addr_o = {pt_q, tile_q, fx_q[2], y_q[FY_W-1:0]};
  assign active_o   = active_q;
  assign lo_stb_o   = fetch && phase == 3'd3;
  assign hi_stb_o   = fetch && phase == 3'd5;
  assign load_o     = active_q && phase == 3'd7;
  assign vis_o      = active_q && (fx_q >= fx_t'(TILE_PX));
  assign attr_o     = attr_q;

  // R7
  fx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && fx_q != fx_t'(LINE_LAST) && !line_start_i) |=> fx_q == $past(fx_q) + fx_t'(1));
  // R4
  hi_plane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch && phase == 3'd4) |-> pat_addr_o == ($past(pat_addr_o, 2) | PAT_AW'(8)));
  // R8
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && !$past(line_start_i)) |-> $stable(nt_addr_o[NT_AW-1]));
endmodule

// File: rtl/bgf_shift.sv
module bgf_shift
  import bgf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              lo_stb_i,
  input  logic              hi_stb_i,
  input  logic              load_i,
  input  logic [7:0]        pat_data_i,
  input  logic [GRP_W-1:0]  attr_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic [GRP_W-1:0]  grp_o
);
  logic [PIX_W-1:0] stb;
  logic [7:0]       lat_q [PIX_W];
  logic [7:0]       sh_q  [PIX_W];
  logic [GRP_W-1:0] grp_q;

  assign stb = {hi_stb_i, lo_stb_i};

  for (genvar pl = 0; pl < PIX_W; pl++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_q[pl] <= '0;
        sh_q[pl]  <= '0;
      end else begin
        if (stb[pl]) lat_q[pl] <= pat_data_i;
        if (load_i)        sh_q[pl] <= lat_q[pl];
        else if (active_i) sh_q[pl] <= {sh_q[pl][6:0], 1'b0};
      end
    end
    assign pix_o[pl] = sh_q[pl][7];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     grp_q <= '0;
    else if (load_i) grp_q <= attr_i;
  end
  assign grp_o = grp_q;

  // R5
  reload_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pix_o == {$past(lat_q[1][7]), $past(lat_q[0][7])});
endmodule

// File: rtl/bgf_pal.sv
module bgf_pal
  import bgf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vis_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [CIDX_W-1:0] pal_data_i,
  output logic [PAL_AW-1:0] pal_addr_o,
  output logic [CIDX_W-1:0] color_o,
  output logic              color_valid_o
);
  logic [PAL_AW-1:0] addr_q;
  logic              v1_q, v2_q, vo_q;
  logic [CIDX_W-1:0] col_q;
  logic [FX_W-1:0]   run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      vo_q   <= 1'b0;
      col_q  <= '0;
    end else begin
      // value 0 maps to the shared backdrop entry
      addr_q <= (pix_i == '0) ? '0 : {1'b0, grp_i, pix_i};
      v1_q   <= vis_i;
      v2_q   <= v1_q;
      vo_q   <= v2_q;
      col_q  <= v2_q ? pal_data_i : '0;
    end
  end

  assign pal_addr_o    = addr_q;
  assign color_o       = col_q;
  assign color_valid_o = vo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (color_valid_o) run_q <= run_q + 1'b1;
    else                    run_q <= '0;
  end

  // R7
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    color_valid_o |-> run_q < FX_W'(LINE_PX));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(vis_i, 1) && !$past(vis_i, 2) && !$past(vis_i, 3)) |-> !color_valid_o);
endmodule

// File: rtl/bg_tile_fetch.sv
module bg_tile_fetch
  import bgf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [7:0]        line_y_i,
  input  logic [1:0]        nt_sel_i,
  input  logic              pt_sel_i,
  input  logic              mirror_i,
  output logic [10:0]       nt_addr_o,
  input  logic [7:0]        nt_tile_i,
  input  logic [1:0]        nt_attr_i,
  output logic [12:0]       pat_addr_o,
  input  logic [7:0]        pat_data_i,
  output logic [4:0]        pal_addr_o,
  input  logic [5:0]        pal_data_i,
  output logic [5:0]        color_o,
  output logic              color_valid_o
);
  logic             active, lo_stb, hi_stb, load, vis;
  logic [GRP_W-1:0] attr, grp;
  logic [PIX_W-1:0] pix;

  bgf_seq u_seq (
    .clk_i, .rst_ni, .line_start_i, .line_y_i, .nt_sel_i, .pt_sel_i, .mirror_i,
    .nt_tile_i, .nt_attr_i, .nt_addr_o, .pat_addr_o,
    .active_o(active), .lo_stb_o(lo_stb), .hi_stb_o(hi_stb), .load_o(load),
    .vis_o(vis), .attr_o(attr)
  );

  bgf_shift u_shift (
    .clk_i, .rst_ni, .active_i(active), .lo_stb_i(lo_stb), .hi_stb_i(hi_stb),
    .load_i(load), .pat_data_i, .attr_i(attr), .pix_o(pix), .grp_o(grp)
  );

  bgf_pal u_pal (
    .clk_i, .rst_ni, .vis_i(vis), .pix_i(pix), .grp_i(grp), .pal_data_i,
    .pal_addr_o, .color_o, .color_valid_o
  );
endmodule

// File: tb/sim_bg_tile_fetch.sv
`timescale 1ns/1ps
module sim_bg_tile_fetch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 1'b0, pt_sel = 1'b0, mirror = 1'b0;
  logic [7:0] line_y = '0;
  logic [1:0] nt_sel = '0;
  logic [10:0] nt_addr;
  logic [12:0] pat_addr;
  logic [4:0]  pal_addr;
  logic [7:0]  nt_tile, pat_data;
  logic [1:0]  nt_attr;
  logic [5:0]  pal_data, color;
  logic        color_valid;

  logic [9:0] ntm [2048];
  logic [7:0] ptm [8192];
  logic [5:0] plm [32];

  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bg_tile_fetch u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .line_y_i(line_y),
    .nt_sel_i(nt_sel), .pt_sel_i(pt_sel), .mirror_i(mirror),
    .nt_addr_o(nt_addr), .nt_tile_i(nt_tile), .nt_attr_i(nt_attr),
    .pat_addr_o(pat_addr), .pat_data_i(pat_data),
    .pal_addr_o(pal_addr), .pal_data_i(pal_data),
    .color_o(color), .color_valid_o(color_valid)
  );

  always @(posedge clk) begin
    {nt_attr, nt_tile} <= ntm[nt_addr];
    pat_data <= ptm[pat_addr];
    pal_data <= plm[pal_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_color(input logic [7:0] y, input logic bank,
                                           input logic pt, input int p);
    logic [9:0] e;
    logic [7:0] lo, hi;
    logic [1:0] px;
    int j;
    e  = ntm[{bank, y[7:3], 5'(p >> 3)}];
    lo = ptm[{pt, e[7:0], 1'b0, y[2:0]}];
    hi = ptm[{pt, e[7:0], 1'b1, y[2:0]}];
    j  = 7 - (p & 7);
    px = {hi[j], lo[j]};
    return (px == 2'b00) ? plm[0] : plm[{1'b0, e[9:8], px}];
  endfunction

  task automatic run_line(input logic [7:0] y, input logic [1:0] ns, input logic ps,
                          input logic mr, input bit scramble);
    logic bank;
    logic [7:0] t0;
    logic [5:0] ex;
    bank = mr ? ns[1] : ns[0];
    @(negedge clk);
    line_y = y; nt_sel = ns; pt_sel = ps; mirror = mr; line_start = 1'b1;
    @(posedge clk);
    #1 line_start = 1'b0;
    if (scramble) begin  // R8: late changes must be ignored
      line_y = 8'($urandom_range(0, 239)); nt_sel = 2'($urandom);
      pt_sel = ~ps; mirror = ~mr;
    end
    @(negedge clk);
    chk(nt_addr == {bank, y[7:3], 5'd0}, "R2/R3 nametable address", nt_addr, {bank, y[7:3], 5'd0});
    t0 = ntm[{bank, y[7:3], 5'd0}][7:0];
    for (int n = 1; n <= 270; n++) begin
      @(negedge clk);
      if (n == 2) chk(pat_addr == {ps, t0, 1'b0, y[2:0]}, "R4 low plane address", pat_addr, {ps, t0, 1'b0, y[2:0]});
      if (n == 4) chk(pat_addr == {ps, t0, 1'b1, y[2:0]}, "R4 high plane address", pat_addr, {ps, t0, 1'b1, y[2:0]});
      if (n == 16) chk(nt_addr == {bank, y[7:3], 5'd2}, "R2 column 2 address", nt_addr, {bank, y[7:3], 5'd2});
      if (n == 10) chk(color_valid == 1'b0, "R7 valid before first pixel", color_valid, 0);
      if (n >= 11 && n < 267) begin
        ex = exp_color(y, bank, ps, n - 11);
        chk(color_valid && color == ex, "R5/R6/R7 pixel colour", {color_valid, color}, {1'b1, ex});
      end
      if (n == 267) chk(color_valid == 1'b0, "R7 valid after last pixel", color_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 2048; i++) ntm[i] = 10'($urandom);
    for (int i = 0; i < 8192; i++) ptm[i] = 8'($urandom);
    for (int i = 0; i < 32; i++)   plm[i] = 6'($urandom_range(0, 51));
    plm[0] = 6'd13;
    #1;
    chk(color_valid == 1'b0 && color == 6'd0, "R1 reset state", {color_valid, color}, 0);
    #20 rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 8 == 0) chk(color_valid == 1'b0 && color == 6'd0, "R1/R9 idle output", {color_valid, color}, 0);
    end
    // directed corners
    run_line(8'd0,   2'b00, 1'b0, 1'b0, 0);
    run_line(8'd239, 2'b10, 1'b1, 1'b1, 0);  // R3 horizontal: bank 1
    run_line(8'd7,   2'b01, 1'b0, 1'b1, 0);  // R3 horizontal: bank 0
    run_line(8'd8,   2'b01, 1'b1, 1'b0, 0);  // R3 vertical: bank 1
    // tile with all-zero planes: R6 backdrop for every pixel in column 0
    ntm[{1'b0, 5'd3, 5'd0}] = {2'b11, 8'hA5};
    ptm[{1'b0, 8'hA5, 1'b0, 3'd4}] = 8'h00;
    ptm[{1'b0, 8'hA5, 1'b1, 3'd4}] = 8'h00;
    run_line(8'd28, 2'b00, 1'b0, 1'b0, 1);
    // R5 plane order: hi=0xF0 lo=0xCC gives 3,3,2,2,1,1,0,0
    ntm[{1'b1, 5'd10, 5'd0}] = {2'b01, 8'h3C};
    ptm[{1'b1, 8'h3C, 1'b0, 3'd2}] = 8'hCC;
    ptm[{1'b1, 8'h3C, 1'b1, 3'd2}] = 8'hF0;
    run_line(8'd82, 2'b11, 1'b1, 1'b0, 1);
    for (int k = 0; k < 6; k++)
      run_line(8'($urandom_range(0, 239)), 2'($urandom), 1'($urandom), 1'($urandom), 1);
    repeat (20) begin
      @(negedge clk);
      chk(color_valid == 1'b0, "R9 quiet after lines", color_valid, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule